// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block turns the oscillator clock of a small 8-bit controller into twelve-clock machine cycles. It drives the pin-level strobes of a multiplexed external memory bus. Once per machine cycle it takes one request from the core. The request is one of three kinds: an opcode fetch from internal memory, an opcode fetch from external memory, or a data-memory read or write. The data-memory access uses either a full 16-bit pointer or an 8-bit register address. The block emits the address-latch pulse (ALE), the program-store strobe (PSEN) and the read and write strobes (RD, WR). Port 0 carries the low address byte and then the data. Port 2 carries the high address byte.

The core watches `take`. While `take` is high, the core holds its request on the inputs, and the block samples the request at the next rising clock edge. That edge also starts the new machine cycle. Below, "clock k" means the k-th clock of a machine cycle, counted from 0 to 11. Clock 0 follows the sampling edge.

A data-memory access replaces the second ALE pulse and both PSEN pulses with a single read or write strobe. Read data on port 0 is captured and handed back on a one-clock valid pulse. A per-cycle control bit silences ALE outside data-memory cycles.

Top module: `xbus_sequencer`

## Requirements
- R1: A machine cycle lasts 12 clocks. `take` is high on exactly one clock of each machine cycle (clock 11). All request inputs, including `ale_off` and `p2_latch`, are sampled at the edge that ends that clock.
- R2: In a cycle that is not a data access and has `ale_off`=0, ALE is high on clocks 0-1 and 6-7, with `ale_oe`=1. ALE therefore pulses at one sixth of the clock rate.
- R3: In a data read or write cycle, ALE is high only on clocks 0-1 and `ale_oe`=1. The second ALE pulse is omitted and `psen_n` stays 1 for the whole cycle.
- R4: In an external fetch cycle, `psen_n` is 0 on clocks 3-5 and 9-11. The first half of the cycle uses the request address A, and the second half uses A+1 (modulo 2^16). In each half, port 0 drives the low byte of that half's address on the half's first three clocks and then floats. Port 2 drives that half's high byte for the whole half.
- R5: In an internal fetch cycle, `psen_n` stays 1, `rd_n` and `wr_n` stay 1, port 0 floats (`p0_oe`=0) and port 2 outputs `p2_latch`.
- R6: With `ale_off`=1, a cycle that is not a data access holds `ale`=1 with `ale_oe`=0. A data cycle keeps the ALE pulse of R3.
- R7: In a data cycle, port 2 outputs `mx_addr[15:8]` when `mx_wide`=1 and `p2_latch` when `mx_wide`=0. It holds that value for all 12 clocks.
- R8: In a data read, `rd_n` is 0 on clocks 5-10. This is six clocks, starting three clocks after ALE falls. Port 0 drives `mx_addr[7:0]` on clocks 0-2 and floats on clocks 3-11.
- R9: In a data read, `p0_in` is sampled at the edge that ends clock 10. During clock 11, `rdata_vld` is 1 and `rdata` holds that byte. `rdata_vld` is 0 on every other clock.
- R10: In a data write, `wr_n` is 0 on clocks 5-10. Port 0 drives `mx_addr[7:0]` on clocks 0-2 and `wdata` on clocks 3-11, and stays unchanged while `wr_n` is low.
- R11: While `rst_n` is 0 (synchronous), the outputs read `psen_n`=1, `rd_n`=1, `wr_n`=1, `p0_oe`=0, `rdata_vld`=0 and `take`=1.
- R12: At most one of `psen_n`, `rd_n` and `wr_n` is low on any clock, and `psen_n` is never low while ALE is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_ext | input | 1 | Fetch from external program memory (1) or internal memory (0) |
| fetch_addr | input | 16 | Fetch address for the first half of the cycle |
| mx_req | input | 1 | Request a data-memory access this cycle |
| mx_write | input | 1 | Data access is a write (1) or a read (0) |
| mx_wide | input | 1 | Data address is a 16-bit pointer (1) or an 8-bit register address (0) |
| mx_addr | input | 16 | Data-memory address |
| wdata | input | 8 | Write data |
| p2_latch | input | 8 | Port 2 output latch value |
| ale_off | input | 1 | Suppress ALE outside data-memory cycles |
| p0_in | input | 8 | Port 0 pin value for reads |
| take | output | 1 | Request inputs are sampled at the next edge |
| ale | output | 1 | Address latch enable |
| ale_oe | output | 1 | Strong drive for ALE (0 = weak pull-up only) |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Port 0 output value |
| p0_oe | output | 1 | Port 0 output enable |
| p2_out | output | 8 | Port 2 output value |
| rdata | output | 8 | Captured read byte |
| rdata_vld | output | 1 | Read byte valid, one clock |

## Verification
The assertions check, on every clock, the following cycle-independent rules:
- the machine-cycle counter wraps regularly;
- the three strobes never overlap, and PSEN stays off while ALE is high;
- port 0 floats under a low `rd_n`;
- port 0 holds its write byte steady under a low `wr_n`;
- the read-valid pulse lasts one clock and follows a read strobe.

Only the bench scenarios show the exact clock positions of each pulse for every kind of cycle. They also show the address chosen for each half, the port 2 source under each addressing form, and the silencing of ALE. The bench covers the fetch address that wraps from FFFFh to 0000h and the byte returned by a read.

// File: rtl/xbus_pkg.sv
// Shared timing constants and the machine-cycle kind for the bus sequencer.
// Assumes a machine cycle of six states of two oscillator clocks each.
package xbus_pkg;
    localparam int STATE_CLKS = 2;
    localparam int CYC_STATES = 6;
    localparam int CYC_CLKS   = STATE_CLKS * CYC_STATES;
    localparam int HALF_CLKS  = CYC_CLKS / 2;
    localparam int STRB_CLKS  = 6;
    localparam int STRB_GAP   = 3;
    localparam int CNT_W      = $clog2(CYC_CLKS);

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t HALF       = cnt_t'(HALF_CLKS);
    localparam cnt_t LAST       = cnt_t'(CYC_CLKS - 1);
    localparam cnt_t ALE_END    = cnt_t'(STATE_CLKS);
    localparam cnt_t ADDR_END   = cnt_t'(STATE_CLKS + 1);
    localparam cnt_t STRB_FIRST = cnt_t'(STATE_CLKS + STRB_GAP);
    localparam cnt_t STRB_LAST  = cnt_t'(STATE_CLKS + STRB_GAP + STRB_CLKS - 1);

    typedef enum logic [1:0] {
        CYC_INT = 2'd0,
        CYC_EXT = 2'd1,
        CYC_RD  = 2'd2,
        CYC_WR  = 2'd3
    } cyc_kind_t;
endpackage

// File: rtl/mc_timer.sv
// Machine-cycle clock counter: counts 0..CYC_CLKS-1 and flags the last clock.
// Assumes a synchronous active-low reset that parks the counter on the last clock.
module mc_timer
    import xbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output cnt_t cnt,
    output logic last
);
    assign last = (cnt == LAST);

    // Advance the position within the machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= LAST;
        else if (last) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (cnt == '0));
    // R1
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/strobe_gen.sv
// Decodes the cycle position and kind into ALE, PSEN, RD, WR and port 0 phases.
// Assumes the kind and ale_off are held constant for the whole machine cycle.
module strobe_gen
    import xbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cnt_t      cnt,
    input  cyc_kind_t kind,
    input  logic      ale_off,
    output logic      ale,
    output logic      ale_oe,
    output logic      psen_n,
    output logic      rd_n,
    output logic      wr_n,
    output logic      addr_ph,
    output logic      data_ph,
    output logic      second_half
);
    cnt_t local_cnt;
    logic is_data;

    assign second_half = (cnt >= HALF);
    assign local_cnt   = second_half ? cnt - HALF : cnt;
    assign is_data     = (kind == CYC_RD) || (kind == CYC_WR);

    // Address-latch pulse: one per data cycle, two otherwise unless silenced.
    always_comb begin
        if (is_data) begin
            ale    = (cnt < ALE_END);
            ale_oe = 1'b1;
        end else if (ale_off) begin
            ale    = 1'b1;
            ale_oe = 1'b0;
        end else begin
            ale    = (local_cnt < ALE_END);
            ale_oe = 1'b1;
        end
    end

    // Read, write and program strobes.
    always_comb begin
        psen_n = !((kind == CYC_EXT) && (local_cnt >= ADDR_END));
        rd_n   = !((kind == CYC_RD) && (cnt >= STRB_FIRST) && (cnt <= STRB_LAST));
        wr_n   = !((kind == CYC_WR) && (cnt >= STRB_FIRST) && (cnt <= STRB_LAST));
    end

    // Port 0 phases: address first, then write data for writes.
    always_comb begin
        addr_ph = ((kind == CYC_EXT) && (local_cnt < ADDR_END)) ||
                  (is_data && (cnt < ADDR_END));
        data_ph = (kind == CYC_WR) && (cnt >= ADDR_END);
    end

    // R12
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);
    // R12
    psen_off_under_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && ale_oe) |-> psen_n);
endmodule

// File: rtl/rd_capture.sv
// Captures the port 0 byte at the last strobe clock of a read and flags it for one clock.
// Assumes cap_en is high for exactly one clock per read cycle.
module rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          vld
);
    // Sample the bus and raise valid for the following clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            vld  <= 1'b0;
        end else begin
            vld <= cap_en;
            if (cap_en) dout <= din;
        end
    end

    // R9
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);
endmodule

// File: rtl/xbus_sequencer.sv
// External bus cycle sequencer: latches one core request per machine cycle and
// drives the multiplexed port 0, port 2 and bus strobes for that cycle.
// Assumes the core holds its request stable while take is high.
module xbus_sequencer
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_ext,
    input  logic [AW-1:0]   fetch_addr,
    input  logic            mx_req,
    input  logic            mx_write,
    input  logic            mx_wide,
    input  logic [AW-1:0]   mx_addr,
    input  logic [DW-1:0]   wdata,
    input  logic [AW-DW-1:0] p2_latch,
    input  logic            ale_off,
    input  logic [DW-1:0]   p0_in,
    output logic            take,
    output logic            ale,
    output logic            ale_oe,
    output logic            psen_n,
    output logic            rd_n,
    output logic            wr_n,
    output logic [DW-1:0]   p0_out,
    output logic            p0_oe,
    output logic [AW-DW-1:0] p2_out,
    output logic [DW-1:0]   rdata,
    output logic            rdata_vld
);
    localparam int HW = AW - DW;

    cnt_t            cnt;
    logic            last;
    cyc_kind_t       kind_q;
    logic [AW-1:0]   faddr_q;
    logic [AW-1:0]   maddr_q;
    logic            wide_q;
    logic [DW-1:0]   wdata_q;
    logic [HW-1:0]   p2_q;
    logic            ale_off_q;
    logic            addr_ph;
    logic            data_ph;
    logic            second_half;
    logic [AW-1:0]   cur_addr;

    mc_timer u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (cnt),
        .last (last)
    );

    assign take = last;

    // Latch the core request at the machine-cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= CYC_INT;
            faddr_q   <= '0;
            maddr_q   <= '0;
            wide_q    <= 1'b0;
            wdata_q   <= '0;
            p2_q      <= '0;
            ale_off_q <= 1'b0;
        end else if (last) begin
            if (mx_req)         kind_q <= mx_write ? CYC_WR : CYC_RD;
            else if (fetch_ext) kind_q <= CYC_EXT;
            else                kind_q <= CYC_INT;
            faddr_q   <= fetch_addr;
            maddr_q   <= mx_addr;
            wide_q    <= mx_wide;
            wdata_q   <= wdata;
            p2_q      <= p2_latch;
            ale_off_q <= ale_off;
        end
    end

    strobe_gen u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt        (cnt),
        .kind       (kind_q),
        .ale_off    (ale_off_q),
        .ale        (ale),
        .ale_oe     (ale_oe),
        .psen_n     (psen_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .addr_ph    (addr_ph),
        .data_ph    (data_ph),
        .second_half(second_half)
    );

    // Select the address of the current half cycle.
    always_comb begin
        if (kind_q == CYC_EXT) cur_addr = second_half ? faddr_q + 1'b1 : faddr_q;
        else                   cur_addr = maddr_q;
    end

    // Port 0 and port 2 multiplexers.
    always_comb begin
        p0_oe  = addr_ph || data_ph;
        p0_out = addr_ph ? cur_addr[DW-1:0] : wdata_q;
        unique case (kind_q)
            CYC_EXT:        p2_out = cur_addr[AW-1:DW];
            CYC_RD, CYC_WR: p2_out = wide_q ? maddr_q[AW-1:DW] : p2_q;
            default:        p2_out = p2_q;
        endcase
    end

    rd_capture #(.DW(DW)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_en((kind_q == CYC_RD) && (cnt == STRB_LAST)),
        .din   (p0_in),
        .dout  (rdata),
        .vld   (rdata_vld)
    );

    // R8
    p0_float_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !p0_oe);
    // R10
    p0_hold_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> (p0_oe && $stable(p0_out)));
    // R9
    vld_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_vld |-> ($past(!rd_n) && rd_n));
endmodule

// File: tb/tb_xbus_sequencer.sv
module tb_xbus_sequencer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_ext, mx_req, mx_write, mx_wide, ale_off;
    logic [15:0] fetch_addr, mx_addr;
    logic [7:0]  wdata, p2_latch, p0_in;
    logic        take, ale, ale_oe, psen_n, rd_n, wr_n, p0_oe, rdata_vld;
    logic [7:0]  p0_out, p2_out, rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_sequencer dut (
        .clk(clk), .rst_n(rst_n), .fetch_ext(fetch_ext), .fetch_addr(fetch_addr),
        .mx_req(mx_req), .mx_write(mx_write), .mx_wide(mx_wide), .mx_addr(mx_addr),
        .wdata(wdata), .p2_latch(p2_latch), .ale_off(ale_off), .p0_in(p0_in),
        .take(take), .ale(ale), .ale_oe(ale_oe), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // kind: 0 internal fetch, 1 external fetch, 2 read, 3 write
    function automatic bit exp_ale(int kind, int k, bit off);
        if (kind >= 2) return k < 2;
        if (off) return 1'b1;
        return (k % 6) < 2;
    endfunction

    function automatic bit exp_p0_oe(int kind, int k);
        case (kind)
            1: return (k % 6) < 3;
            2: return k < 3;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] exp_p0(int kind, int k, logic [15:0] fa,
                                          logic [15:0] ma, logic [7:0] wd);
        logic [15:0] a2;
        a2 = fa + 16'd1;
        if (kind == 1) return (k < 6) ? fa[7:0] : a2[7:0];
        if (k < 3) return ma[7:0];
        return wd;
    endfunction

    function automatic logic [7:0] exp_p2(int kind, int k, logic [15:0] fa,
                                          logic [15:0] ma, bit wide, logic [7:0] p2);
        logic [15:0] a2;
        a2 = fa + 16'd1;
        if (kind == 1) return (k < 6) ? fa[15:8] : a2[15:8];
        if (kind >= 2) return wide ? ma[15:8] : p2;
        return p2;
    endfunction

    // Drive one request while take is high, then check all 12 clocks of its cycle.
    task automatic run_cycle(input int kind, input logic [15:0] fa, input logic [15:0] ma,
                             input bit wide, input logic [7:0] wd, input logic [7:0] p2,
                             input bit off, input logic [7:0] bus);
        string tp;
        fetch_ext  = (kind == 1);
        mx_req     = (kind >= 2);
        mx_write   = (kind == 3);
        mx_wide    = wide;
        fetch_addr = fa;
        mx_addr    = ma;
        wdata      = wd;
        p2_latch   = p2;
        ale_off    = off;
        p0_in      = bus;
        tp = (kind == 0) ? "R5" : (kind == 1) ? "R4" : (kind == 2) ? "R8" : "R10";
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (kind >= 2) begin
                chk("R3 ale", ale, exp_ale(kind, k, off));
                chk("R3 ale_oe", ale_oe, 1);
                chk("R3 psen_n", psen_n, 1);
            end else if (off) begin
                chk("R6 ale", ale, 1);
                chk("R6 ale_oe", ale_oe, 0);
            end else begin
                chk("R2 ale", ale, exp_ale(kind, k, off));
                chk("R2 ale_oe", ale_oe, 1);
            end
            if (kind < 2) chk({tp, " psen_n"}, psen_n, !((kind == 1) && ((k % 6) >= 3)));
            chk("R8 rd_n", rd_n, !((kind == 2) && k >= 5 && k <= 10));
            chk("R10 wr_n", wr_n, !((kind == 3) && k >= 5 && k <= 10));
            chk({tp, " p0_oe"}, p0_oe, exp_p0_oe(kind, k));
            if (exp_p0_oe(kind, k)) chk({tp, " p0_out"}, p0_out, exp_p0(kind, k, fa, ma, wd));
            if (kind >= 2) chk("R7 p2_out", p2_out, exp_p2(kind, k, fa, ma, wide, p2));
            else           chk({tp, " p2_out"}, p2_out, exp_p2(kind, k, fa, ma, wide, p2));
            chk("R9 rdata_vld", rdata_vld, (kind == 2) && (k == 11));
            if (kind == 2 && k == 11) chk("R9 rdata", rdata, bus);
            chk("R1 take", take, k == 11);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst_n = 1'b0;
        fetch_ext = 0; mx_req = 0; mx_write = 0; mx_wide = 0; ale_off = 0;
        fetch_addr = '0; mx_addr = '0; wdata = '0; p2_latch = '0; p0_in = '0;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 psen_n", psen_n, 1);
        chk("R11 rd_n", rd_n, 1);
        chk("R11 wr_n", wr_n, 1);
        chk("R11 p0_oe", p0_oe, 0);
        chk("R11 rdata_vld", rdata_vld, 0);
        chk("R11 take", take, 1);
        rst_n = 1'b1;

        // Directed corners
        run_cycle(1, 16'hFFFF, 16'h0000, 0, 8'h00, 8'h11, 0, 8'h00); // R4 wrap
        run_cycle(0, 16'h1234, 16'h0000, 0, 8'h00, 8'h5A, 0, 8'h00); // R5
        run_cycle(2, 16'h0000, 16'hBEEF, 1, 8'h00, 8'h77, 0, 8'hC3); // R7 wide, R9
        run_cycle(2, 16'h0000, 16'hBEEF, 0, 8'h00, 8'h77, 0, 8'h3C); // R7 narrow
        run_cycle(3, 16'h0000, 16'h4321, 1, 8'hA5, 8'h66, 1, 8'h00); // R10, R6
        run_cycle(1, 16'h80FF, 16'h0000, 0, 8'h00, 8'h22, 1, 8'h00); // R6 silenced
        run_cycle(3, 16'h0000, 16'h00FE, 0, 8'h5A, 8'h99, 0, 8'h00); // R10 narrow

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            run_cycle(int'($urandom_range(0, 3)), 16'($urandom), 16'($urandom),
                      1'($urandom), 8'($urandom), 8'($urandom),
                      ($urandom_range(0, 3) == 0), 8'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule